// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the digital core of a byte-addressed serial memory that answers as a slave on a two-wire bus. The raw clock and data lines are sampled with the system clock. Start and stop conditions are recovered from them, and bits are shifted in and out on the bus clock edges. The data line is never driven high. The block only asserts a pull-down enable, and the pad and pull-up are outside it.

A master selects the device with a control byte. The byte carries a fixed device code, three chip-select bits and a direction bit. For a write the master then sends a two-byte word address and data bytes. The data bytes collect in a page buffer, and a Stop starts a modelled programming cycle. When that cycle expires, the buffer is committed to a register array. For a read the block streams bytes from its address pointer until the master withholds its acknowledge. While the programming cycle runs, the device ignores its control byte entirely, so the master can poll for completion. A write-protect input suppresses programming and leaves reads untouched.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A falling SDA while synchronised SCL is high is a Start. It aborts any transfer in progress and begins decoding a new control byte, even in the middle of a byte.
- R2: A rising SDA while SCL is high is a Stop. It returns the block to idle with SDA released. A programming cycle starts only if at least one data byte was received since the last Stop.
- R3: Bits are sampled on the SCL rising edge, most significant bit first. The pull-down enable changes only while SCL is low.
- R4: For every accepted byte the block asserts the pull-down for the ninth SCL pulse, across its whole high period, and drops it after that pulse's falling edge.
- R5: A control byte is accepted only under all of these conditions: bits 7:4 equal 4'b1010, bit 3 is 1, `cs_fixed_i` is 1, and bits 2:1 equal `cs_strap_i`. Bit 0 set means read. Any other control byte gets no acknowledge, and the block idles until the next Start.
- R6: After a write control byte, the next two bytes form the word address, high byte first. Only the low log2(MEM_DEPTH) bits are kept. Each following data byte lands at the pointer, and the pointer then increments with wrap inside its PAGE_BYTES-aligned page.
- R7: If `wr_protect_i` is high at the Stop, no programming cycle starts and the array keeps its contents. Bytes are still acknowledged.
- R8: A programming cycle lasts BUSY_CYCLES clocks. During it, no control byte of any direction is acknowledged. At its end the buffered bytes are written to the array.
- R9: A read control byte returns the byte at the pointer, and the pointer then increments with wrap at the array end. A read without a preceding address continues from where the pointer stands.
- R10: If the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next Start.
- R11: SDA is only ever pulled low. The output is a pull-down enable and is low out of reset and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line as seen on the wire |
| cs_strap_i | input | 2 | Configurable chip-select straps compared with control bits 2:1 |
| cs_fixed_i | input | 1 | Chip-select strap that must be high for any response |
| wr_protect_i | input | 1 | High blocks programming |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
The bench builds the block with MEM_DEPTH 256, PAGE_BYTES 16 and BUSY_CYCLES 600. The small page lets a four-byte write at offset 14 wrap past the page end. The 256-byte array lets a two-byte sequential read cross from the last address back to zero. The busy window of 600 clocks outlasts one full poll attempt, so at least one control byte is refused while programming runs. It is still short enough that every polling loop finishes in a few attempts.

// File: rtl/seep_pkg.sv
package seep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } seep_state_e;

  typedef enum logic [1:0] {
    K_CTRL, K_AHI, K_ALO, K_DATA
  } seep_kind_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/seep_line_sync.sv
module seep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw;
  logic [1:0] synced;
  logic [1:0] prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b11;
    else         prev_q <= synced;
  end

  assign scl_o      = synced[0];
  assign sda_o      = synced[1];
  assign scl_rise_o = synced[0] & ~prev_q[0];
  assign scl_fall_o = ~synced[0] & prev_q[0];
  assign start_o    = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
  assign stop_o     = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];
endmodule

// File: rtl/seep_store.sv
module seep_store #(
  parameter int MEM_DEPTH   = 256,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 5000,
  localparam int AW = $clog2(MEM_DEPTH),
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          buf_clear_i,
  input  logic          buf_we_i,
  input  logic [AW-1:0] buf_addr_i,
  input  logic [7:0]    buf_data_i,
  input  logic          commit_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o
);
  localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);

  logic [7:0]            mem   [MEM_DEPTH];
  logic [7:0]            pbuf  [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvld_q;
  logic [AW-1:0]         base_q;
  logic [CW-1:0]         cnt_q;
  logic                  commit_now;

  assign commit_now = (cnt_q == CW'(1));
  assign busy_o     = (cnt_q != '0);
  assign rd_data_o  = mem[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pvld_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (commit_i)          cnt_q <= CW'(BUSY_CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
      if (buf_clear_i || commit_now) pvld_q <= '0;
      else if (buf_we_i) begin
        pvld_q[buf_addr_i[PW-1:0]] <= 1'b1;
        base_q <= buf_addr_i & ~PMASK;
      end
    end
  end

  // storage: no reset
  always_ff @(posedge clk_i) begin
    if (buf_we_i) pbuf[buf_addr_i[PW-1:0]] <= buf_data_i;
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (commit_now && pvld_q[i]) mem[base_q | AW'(i)] <= pbuf[i];
    end
  end
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import seep_pkg::*;
#(
  parameter int MEM_DEPTH   = 256,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] cs_strap_i,
  input  logic       cs_fixed_i,
  input  logic       wr_protect_i,
  output logic       sda_pull_o
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  seep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  seep_state_e   st_q;
  seep_kind_e    kind_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    rx_sh_q, addr_hi_q, tx_q;
  logic [AW-1:0] ptr_q;
  logic          is_read_q, wr_pend_q, m_ack_q, pull_q;
  logic [7:0]    rd_data;
  logic          busy;

  logic byte_end, ctrl_hit, buf_we, buf_clear, commit_req;
  logic [AW-1:0] ptr_page_inc;

  assign byte_end   = scl_fall && (st_q == ST_RX) && (bit_cnt_q == 4'd8);
  assign ctrl_hit   = (rx_sh_q[7:4] == DEV_CODE) && rx_sh_q[3] && cs_fixed_i
                      && (rx_sh_q[2:1] == cs_strap_i) && !busy;
  assign buf_we     = byte_end && (kind_q == K_DATA);
  assign buf_clear  = byte_end && (kind_q == K_CTRL) && ctrl_hit && !rx_sh_q[0];
  assign commit_req = stop_det && wr_pend_q && !wr_protect_i;
  assign ptr_page_inc = (ptr_q & ~PMASK) | ((ptr_q + AW'(1)) & PMASK);
  assign sda_pull_o = pull_q;

  seep_store #(
    .MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_store (
    .clk_i, .rst_ni,
    .buf_clear_i(buf_clear), .buf_we_i(buf_we), .buf_addr_i(ptr_q),
    .buf_data_i(rx_sh_q), .commit_i(commit_req),
    .rd_addr_i(ptr_q), .rd_data_o(rd_data), .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      kind_q    <= K_CTRL;
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      addr_hi_q <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      is_read_q <= 1'b0;
      wr_pend_q <= 1'b0;
      m_ack_q   <= 1'b0;
      pull_q    <= 1'b0;
    end else if (start_det) begin
      st_q      <= ST_RX;
      kind_q    <= K_CTRL;
      bit_cnt_q <= '0;
      pull_q    <= 1'b0;
    end else if (stop_det) begin
      st_q      <= ST_IDLE;
      pull_q    <= 1'b0;
      wr_pend_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && bit_cnt_q < 4'd8) begin
            rx_sh_q   <= {rx_sh_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_end) begin
            if (kind_q != K_CTRL || ctrl_hit) begin
              pull_q <= 1'b1;
              st_q   <= ST_RX_ACK;
            end else begin
              st_q <= ST_IDLE;
            end
            unique case (kind_q)
              K_CTRL: is_read_q <= rx_sh_q[0];
              K_AHI:  addr_hi_q <= rx_sh_q;
              K_ALO:  ptr_q     <= AW'({addr_hi_q, rx_sh_q});
              K_DATA: begin
                ptr_q     <= ptr_page_inc;
                wr_pend_q <= 1'b1;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (kind_q == K_CTRL && is_read_q) begin
              st_q   <= ST_TX;
              tx_q   <= rd_data;
              ptr_q  <= ptr_q + AW'(1);
              pull_q <= ~rd_data[7];
            end else begin
              st_q   <= ST_RX;
              pull_q <= 1'b0;
              unique case (kind_q)
                K_CTRL:  kind_q <= K_AHI;
                K_AHI:   kind_q <= K_ALO;
                default: kind_q <= K_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt_q == 4'd8) begin
              pull_q <= 1'b0;
              st_q   <= ST_TX_ACK;
            end else begin
              pull_q <= ~tx_q[~bit_cnt_q[2:0]];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            m_ack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack_q) begin
              st_q      <= ST_TX;
              bit_cnt_q <= '0;
              tx_q      <= rd_data;
              ptr_q     <= ptr_q + AW'(1);
              pull_q    <= ~rd_data[7];
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seep_checker.sv
module seep_checker
  import seep_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_s,
  input logic        sda_pull,
  input seep_state_e st,
  input seep_kind_e  kind,
  input logic [3:0]  bit_cnt,
  input logic        busy,
  input logic        wp,
  input logic        cs_fixed
);
  AST_PULL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pull != $past(sda_pull)) |-> !scl_s); // R3
  AST_ACK_PULLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RX_ACK) |-> sda_pull); // R4
  AST_BUSY_NO_CTRL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RX_ACK && kind == K_CTRL) |-> (!busy && cs_fixed)); // R8
  AST_WP_NO_PROGRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !$past(wp)); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_pull); // R10
  AST_BITCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= 4'd8); // R3
endmodule

bind serial_eeprom_slave seep_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_pull(sda_pull_o),
  .st(st_q), .kind(kind_q), .bit_cnt(bit_cnt_q), .busy(busy),
  .wp(wr_protect_i), .cs_fixed(cs_fixed_i)
);

// File: tb/serial_eeprom_slave_tb_top.sv
module serial_eeprom_slave_tb_top;
  localparam int H = 10;
  localparam int Q = 5;
  localparam logic [7:0] CW_B = 8'hAC;  // 1010_1_10_0
  localparam logic [7:0] CR_B = 8'hAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic fixed = 1'b1, wp = 1'b0;
  logic pull;
  wire  sda_bus = sda_m & ~pull;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  serial_eeprom_slave #(.MEM_DEPTH(256), .PAGE_BYTES(16), .BUSY_CYCLES(600)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .cs_strap_i(strap), .cs_fixed_i(fixed), .wr_protect_i(wp), .sda_pull_o(pull)
  );

  // {addr, data, wp, expected}
  localparam logic [32:0] VEC [6] = '{
    {16'h0010, 8'hA5, 1'b0, 8'hA5},
    {16'h0011, 8'h3C, 1'b0, 8'h3C},
    {16'h0010, 8'hFF, 1'b1, 8'hA5},
    {16'h00FF, 8'h81, 1'b0, 8'h81},
    {16'h0000, 8'h5A, 1'b0, 8'h5A},
    {16'h0011, 8'h77, 1'b1, 8'h3C}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(H); sda_m = 1'b0; w(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(H); sda_m = 1'b1; w(H);
  endtask

  task automatic put_bit(input logic b);
    w(Q); sda_m = b; w(Q); scl_m = 1'b1; w(H); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); b = sda_bus; w(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!mack);
  endtask

  task automatic write_seq(input logic [15:0] a, input int n, input logic [31:0] d);
    bit ack, all_ok;
    all_ok = 1'b1;
    bus_start();
    send_byte(CW_B, ack);      all_ok &= ack;
    send_byte(a[15:8], ack);   all_ok &= ack;
    send_byte(a[7:0], ack);    all_ok &= ack;
    for (int i = 0; i < n; i++) begin
      send_byte(d[31-8*i -: 8], ack); all_ok &= ack;
    end
    bus_stop();
    chk(all_ok, "R4 write bytes acknowledged", 32'(all_ok), 32'd1);
  endtask

  task automatic poll(output int nacks);
    bit ack;
    nacks = 0;
    for (int k = 0; k < 40; k++) begin
      bus_start();
      send_byte(CW_B, ack);
      bus_stop();
      if (ack) break;
      nacks++;
    end
  endtask

  task automatic read_seq(input logic [15:0] a, input int n, output logic [31:0] d);
    bit ack;
    logic [7:0] b;
    d = '0;
    bus_start();
    send_byte(CW_B, ack);
    send_byte(a[15:8], ack);
    send_byte(a[7:0], ack);
    bus_start();
    send_byte(CR_B, ack);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      d[31-8*i -: 8] = b;
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int nk;
    bit ack;
    logic [31:0] rd;
    logic [7:0] b;
    w(5);
    rst_n = 1'b1;
    w(5);
    chk(pull == 1'b0, "R11 released after reset", 32'(pull), 32'd0);

    // vector table: single-byte write, poll, read back
    for (int v = 0; v < 6; v++) begin
      wp = VEC[v][8];
      write_seq(VEC[v][32:17], 1, {VEC[v][16:9], 24'h0});
      poll(nk);
      if (VEC[v][8]) chk(nk == 0, "R7 no programming under write-protect", 32'(nk), 32'd0);
      else           chk(nk > 0, "R8 control byte refused while busy", 32'(nk), 32'd1);
      wp = 1'b0;
      read_seq(VEC[v][32:17], 1, rd);
      chk(rd[31:24] == VEC[v][7:0], "R3 R6 R7 readback", 32'(rd[31:24]), 32'(VEC[v][7:0]));
    end

    // page wrap
    write_seq(16'h003E, 4, 32'h11223344);
    poll(nk);
    read_seq(16'h003E, 2, rd);
    chk(rd[31:16] == 16'h1122, "R6 bytes before page end", rd[31:16], 32'h1122);
    read_seq(16'h0030, 2, rd);
    chk(rd[31:16] == 16'h3344, "R6 wrap to page start", rd[31:16], 32'h3344);

    // array wrap on sequential read
    read_seq(16'h00FF, 2, rd);
    chk(rd[31:16] == 16'h815A, "R9 sequential read wraps array", rd[31:16], 32'h815A);

    // current-address read
    read_seq(16'h0010, 1, rd);
    bus_start();
    send_byte(CR_B, ack);
    recv_byte(b, 1'b0);
    chk(pull == 1'b0, "R10 released after master nack", 32'(pull), 32'd0);
    bus_stop();
    chk(b == 8'h3C, "R9 current address read", 32'(b), 32'h3C);

    // address mismatches
    bus_start(); send_byte(8'hAA, ack); bus_stop();
    chk(!ack, "R5 strap mismatch", 32'(ack), 32'd0);
    bus_start(); send_byte(8'hA4, ack); bus_stop();
    chk(!ack, "R5 fixed select bit zero", 32'(ack), 32'd0);
    bus_start(); send_byte(8'h2C, ack); bus_stop();
    chk(!ack, "R5 wrong device code", 32'(ack), 32'd0);
    fixed = 1'b0;
    bus_start(); send_byte(CW_B, ack); bus_stop();
    chk(!ack, "R5 fixed strap low", 32'(ack), 32'd0);
    fixed = 1'b1;
    bus_start(); send_byte(CW_B, ack); bus_stop();
    chk(ack, "R5 matching control byte", 32'(ack), 32'd1);

    // start in the middle of a byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte(CW_B, ack);
    bus_stop();
    chk(ack, "R1 restart mid-byte", 32'(ack), 32'd1);

    // stop after address only: no programming
    bus_start();
    send_byte(CW_B, ack);
    send_byte(8'h00, ack);
    bus_stop();
    chk(pull == 1'b0, "R2 released after stop", 32'(pull), 32'd0);
    poll(nk);
    chk(nk == 0, "R2 no programming without data", 32'(nk), 32'd0);

    // read attempt during programming, then commit
    write_seq(16'h0050, 1, 32'h55000000);
    bus_start(); send_byte(CR_B, ack); bus_stop();
    chk(!ack, "R8 read control refused while busy", 32'(ack), 32'd0);
    poll(nk);
    read_seq(16'h0050, 1, rd);
    chk(rd[31:24] == 8'h55, "R8 commit at end of cycle", 32'(rd[31:24]), 32'h55);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule